// File: doc/BRIEF.md
# Dual-Stage Logic Analyzer Trigger

This block watches a stream of sampled logic-analyzer words and decides when to stop the capture. It holds two condition units, A and B. Each unit looks for edges, levels, pulse widths of a level, and edges qualified by a second channel. Each unit also has an occurrence counter, so it fires only on the Nth match. A combiner merges the two units: both must have fired, either may fire, or A must fire first and B after it.

Software loads the conditions through a small register write port. It then pulses `arm`. Samples arrive on a valid/ready stream. The block never applies back-pressure: `smp_ready` is always high, and a word is taken on every cycle that `smp_valid` is high. When the combined condition is met, the block emits a one-cycle `trig_pulse` and holds `triggered` until the next arm.

Top module: `la_trigger`

## Requirements
- R1: After reset, `trig_pulse`, `triggered` and `armed` are low. `smp_ready` is high at all times: there is no back-pressure.
- R2: Register address layout: `cfg_addr[4]`=0 selects a unit register, with `cfg_addr[3]` choosing the unit (0=A, 1=B) and `cfg_addr[2:0]` choosing the register. `cfg_addr[4]`=1 selects the mode register. In unit register 0, bits [CH-1:0] form the rising-edge channel mask and bits [16+:CH] form the falling-edge mask. Setting both masks on a channel gives any-edge. An edge is found by comparing a sample with the previous accepted sample, so the first accepted sample after arming never matches an edge.
- R3: In unit register 1, bits [CH-1:0] enable level checks and bits [16+:CH] give the required value for each channel. The level part matches only when every enabled channel equals its value.
- R4: Unit register 2 holds the qualified edge. Bit 0 enables it, bit 1 selects rising and bit 2 selects falling (both set means any edge). Bits [4+:log2 CH] give the edge channel and bits [8+:log2 CH] give the qualifier channel. Bit 12 gives the level the qualifier must have in the same sample.
- R5: Inside one unit, the edge terms (masked edges and the qualified edge) are ORed together. When a unit has both edge and level terms, it matches only if both parts are true. A unit with no terms never matches.
- R6: Bit 16 of unit register 2 enables the pulse-width mode. In this mode the level part is true only on the sample where the level condition ends. The run length L is the number of consecutive accepted samples for which the condition held, and the level part is true only if min ≤ L ≤ max. Unit register 3 holds min in bits [0+:PW_W] and max in bits [16+:PW_W]. L saturates at 2^PW_W−1 and does not wrap.
- R7: Unit register 4, bits [0+:CNT_W], hold the count N. The unit fires on its Nth matching sample, and N=0 behaves as N=1.
- R8: Mode register bits [1:0]: 0 = AND, which triggers once both units have fired since arming; 1 = OR, which triggers on the first unit to fire; 3 behaves as AND.
- R9: Mode 2 = THEN. Unit B ignores every sample up to and including the sample on which A fires. The trigger occurs when B then fires.
- R10: `trig_pulse` is high for exactly one cycle, in the cycle after the clock edge that accepts the firing sample. At that edge `triggered` is set and `armed` is cleared, and no further pulse occurs until the next arm. Arming clears the match counts, the THEN sequence state, the run length and the edge history.
- R11: A sample is accepted only when `armed` and `smp_valid` are high and `arm` is low. All other samples have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register address |
| cfg_wdata | input | 32 | Register write data |
| arm | input | 1 | Arm pulse; clears the matching state |
| smp_valid | input | 1 | Sample word is valid |
| smp_ready | output | 1 | Always high; samples are never stalled |
| smp_data | input | CH | Sampled channel word |
| trig_pulse | output | 1 | One-cycle trigger pulse |
| triggered | output | 1 | Latched trigger flag |
| armed | output | 1 | Block is armed and watching samples |

## Verification
The bench builds the block with CH=4, CNT_W=3 and PW_W=3. With four channels, the level check can be swept over every required value against every sample word. Edge kinds can be tried on every channel while the other channels toggle. A three-bit run counter saturates at 7, so a pulse of ten samples tells saturation apart from wrap-around. Counts from 0 to 4 and all four combiner modes, including the reserved code, are driven with short sample sequences whose trigger points are worked out in the bench.

// File: rtl/la_trig_pkg.sv
package la_trig_pkg;

  typedef enum logic [1:0] {
    CMB_AND  = 2'd0,
    CMB_OR   = 2'd1,
    CMB_THEN = 2'd2,
    CMB_RSVD = 2'd3
  } cmb_mode_e;

  // unit register selectors (cfg_addr[2:0])
  localparam logic [2:0] RG_EDGE  = 3'd0;
  localparam logic [2:0] RG_LEVEL = 3'd1;
  localparam logic [2:0] RG_QUAL  = 3'd2;
  localparam logic [2:0] RG_PULSE = 3'd3;
  localparam logic [2:0] RG_COUNT = 3'd4;

  // bit offset of the upper field in paired registers
  localparam int unsigned HI_OFS = 16;

endpackage

// File: rtl/trig_unit.sv
module trig_unit #(
  parameter int unsigned CH    = 16,
  parameter int unsigned CNT_W = 8,
  parameter int unsigned PW_W  = 16,
  parameter int unsigned CHW   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             act,
  input  logic             en,
  input  logic [CH-1:0]    smp,
  input  logic [CH-1:0]    prev,
  input  logic             prev_vld,
  input  logic [CH-1:0]    rise_m,
  input  logic [CH-1:0]    fall_m,
  input  logic [CH-1:0]    lvl_en,
  input  logic [CH-1:0]    lvl_val,
  input  logic             qe_en,
  input  logic             qe_rise,
  input  logic             qe_fall,
  input  logic [CHW-1:0]   qe_ch,
  input  logic [CHW-1:0]   ql_ch,
  input  logic             ql_val,
  input  logic             pw_en,
  input  logic [PW_W-1:0]  pw_min,
  input  logic [PW_W-1:0]  pw_max,
  input  logic [CNT_W-1:0] need,
  output logic             hit,
  output logic             done
);

  localparam logic [PW_W-1:0] RUN_MAX = '1;

  logic [CH-1:0]    ch_rise, ch_fall;
  logic             edge_mask_hit, qual_hit, edge_ok;
  logic             has_edge, has_lvl, lvl_now, lvl_ok, pulse_end, match;
  logic [PW_W-1:0]  run_q;
  logic [CNT_W-1:0] cnt_q, need_eff;
  logic [CNT_W:0]   cnt_nx;
  logic             reach, done_q;

  // edge detection against the previous accepted sample
  assign ch_rise       = smp & ~prev;
  assign ch_fall       = ~smp & prev;
  assign edge_mask_hit = prev_vld & (|((rise_m & ch_rise) | (fall_m & ch_fall)));
  assign qual_hit      = prev_vld & qe_en
                       & ((qe_rise & ch_rise[qe_ch]) | (qe_fall & ch_fall[qe_ch]))
                       & (smp[ql_ch] == ql_val);
  assign edge_ok       = edge_mask_hit | qual_hit;
  assign has_edge      = (|rise_m) | (|fall_m) | qe_en;

  // level terms are ANDed over the enabled channels
  assign has_lvl = |lvl_en;
  assign lvl_now = has_lvl & ((~(smp ^ lvl_val) & lvl_en) == lvl_en);

  // run length of the level condition, saturating
  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      run_q <= '0;
    end else if (act) begin
      if (!lvl_now)             run_q <= '0;
      else if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
    end
  end

  assign pulse_end = (run_q != '0) & ~lvl_now & (run_q >= pw_min) & (run_q <= pw_max);
  assign lvl_ok    = pw_en ? pulse_end : lvl_now;
  assign match     = (has_edge | has_lvl) & (~has_edge | edge_ok) & (~has_lvl | lvl_ok);

  // occurrence counter
  assign need_eff = (need == '0) ? CNT_W'(1) : need;
  assign cnt_nx   = {1'b0, cnt_q} + (CNT_W + 1)'(1);
  assign reach    = cnt_nx >= {1'b0, need_eff};
  assign hit      = act & en & ~done_q & match & reach;
  assign done     = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (act && en && !done_q && match) begin
      if (reach) done_q <= 1'b1;
      else       cnt_q  <= cnt_q + 1'b1;
    end
  end

  // R11: no accepted, enabled sample leaves the count alone
  a_r11_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !clr && !(act && en) |=> $stable(cnt_q));

  // R6: a saturated run stays saturated while the level holds
  a_r6_run_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q == RUN_MAX) && act && lvl_now && !clr |=> (run_q == RUN_MAX));

  // R7: once fired, the unit stays fired until cleared
  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && !clr |=> done_q);

endmodule

// File: rtl/trig_combiner.sv
module trig_combiner
  import la_trig_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      act,
  input  cmb_mode_e mode,
  input  logic      hit_a,
  input  logic      done_a,
  input  logic      hit_b,
  input  logic      done_b,
  output logic      en_b,
  output logic      fire
);

  logic a_f, b_f;

  assign a_f  = hit_a | done_a;
  assign b_f  = hit_b | done_b;
  assign en_b = (mode != CMB_THEN) | done_a;

  always_comb begin
    unique case (mode)
      CMB_OR:   fire = act & (a_f | b_f);
      CMB_THEN: fire = act & hit_b;
      default:  fire = act & a_f & b_f;
    endcase
  end

  // R9: in sequence mode the trigger needs A to have fired earlier
  a_r9_b_after_a: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CMB_THEN) && fire |-> done_a);

  // R8: in OR mode the firing sample is a fresh unit hit
  a_r8_or_fresh_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CMB_OR) && fire |-> (hit_a || hit_b));

endmodule

// File: rtl/la_trigger.sv
module la_trigger
  import la_trig_pkg::*;
#(
  parameter int unsigned CH    = 16,
  parameter int unsigned CNT_W = 8,
  parameter int unsigned PW_W  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [4:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  input  logic          arm,
  input  logic          smp_valid,
  output logic          smp_ready,
  input  logic [CH-1:0] smp_data,
  output logic          trig_pulse,
  output logic          triggered,
  output logic          armed
);

  localparam int unsigned CHW     = (CH > 1) ? $clog2(CH) : 1;
  localparam int unsigned N_UNITS = 2;

  logic                act;
  logic [CH-1:0]       prev_q;
  logic                prev_vld;
  logic [N_UNITS-1:0]  hit_v, done_v, en_v;
  logic                en_b, fire;
  cmb_mode_e           mode_q;
  logic                unused_wdata;

  assign smp_ready    = 1'b1;
  assign act          = armed & smp_valid & ~arm;
  assign unused_wdata = ^cfg_wdata;

  // previous accepted sample for edge detection
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q   <= '0;
      prev_vld <= 1'b0;
    end else if (arm) begin
      prev_vld <= 1'b0;
    end else if (act) begin
      prev_q   <= smp_data;
      prev_vld <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                        mode_q <= CMB_AND;
    else if (cfg_we && cfg_addr[4])    mode_q <= cmb_mode_e'(cfg_wdata[1:0]);
  end

  assign en_v = {en_b, 1'b1};

  for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
    logic [CH-1:0]    rise_m, fall_m, lvl_en, lvl_val;
    logic             qe_en, qe_rise, qe_fall, ql_val, pw_en;
    logic [CHW-1:0]   qe_ch, ql_ch;
    logic [PW_W-1:0]  pw_min, pw_max;
    logic [CNT_W-1:0] need;
    logic             sel;

    assign sel = cfg_we && !cfg_addr[4] && (cfg_addr[3] == 1'(u));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rise_m <= '0; fall_m <= '0; lvl_en <= '0; lvl_val <= '0;
        qe_en  <= 1'b0; qe_rise <= 1'b0; qe_fall <= 1'b0;
        qe_ch  <= '0; ql_ch <= '0; ql_val <= 1'b0; pw_en <= 1'b0;
        pw_min <= '0; pw_max <= '0; need <= CNT_W'(1);
      end else if (sel) begin
        case (cfg_addr[2:0])
          RG_EDGE: begin
            rise_m <= cfg_wdata[0 +: CH];
            fall_m <= cfg_wdata[HI_OFS +: CH];
          end
          RG_LEVEL: begin
            lvl_en  <= cfg_wdata[0 +: CH];
            lvl_val <= cfg_wdata[HI_OFS +: CH];
          end
          RG_QUAL: begin
            qe_en   <= cfg_wdata[0];
            qe_rise <= cfg_wdata[1];
            qe_fall <= cfg_wdata[2];
            qe_ch   <= cfg_wdata[4 +: CHW];
            ql_ch   <= cfg_wdata[8 +: CHW];
            ql_val  <= cfg_wdata[12];
            pw_en   <= cfg_wdata[HI_OFS];
          end
          RG_PULSE: begin
            pw_min <= cfg_wdata[0 +: PW_W];
            pw_max <= cfg_wdata[HI_OFS +: PW_W];
          end
          RG_COUNT: need <= cfg_wdata[0 +: CNT_W];
          default: ;
        endcase
      end
    end

    trig_unit #(
      .CH(CH), .CNT_W(CNT_W), .PW_W(PW_W), .CHW(CHW)
    ) u_unit (
      .clk(clk), .rst_n(rst_n), .clr(arm), .act(act), .en(en_v[u]),
      .smp(smp_data), .prev(prev_q), .prev_vld(prev_vld),
      .rise_m(rise_m), .fall_m(fall_m), .lvl_en(lvl_en), .lvl_val(lvl_val),
      .qe_en(qe_en), .qe_rise(qe_rise), .qe_fall(qe_fall),
      .qe_ch(qe_ch), .ql_ch(ql_ch), .ql_val(ql_val),
      .pw_en(pw_en), .pw_min(pw_min), .pw_max(pw_max), .need(need),
      .hit(hit_v[u]), .done(done_v[u])
    );
  end

  trig_combiner u_cmb (
    .clk(clk), .rst_n(rst_n), .act(act), .mode(mode_q),
    .hit_a(hit_v[0]), .done_a(done_v[0]),
    .hit_b(hit_v[1]), .done_b(done_v[1]),
    .en_b(en_b), .fire(fire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed      <= 1'b0;
      triggered  <= 1'b0;
      trig_pulse <= 1'b0;
    end else begin
      trig_pulse <= 1'b0;
      if (arm) begin
        armed     <= 1'b1;
        triggered <= 1'b0;
      end else if (fire) begin
        armed      <= 1'b0;
        triggered  <= 1'b1;
        trig_pulse <= 1'b1;
      end
    end
  end

  // R10: the pulse never lasts two cycles
  a_r10_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |=> !trig_pulse);

  // R10: the flag holds until the next arm
  a_r10_flag_held: assert property (@(posedge clk) disable iff (!rst_n)
    triggered && !arm |=> triggered);

  // R10: a pulse comes with the flag set and the block disarmed
  a_r10_pulse_marks: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> triggered && !armed);

  // R11: a disarmed block produces no pulse
  a_r11_idle_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !trig_pulse);

endmodule

// File: tb/tb_la_trigger.sv
module tb_la_trigger;
  localparam int CLK_PERIOD = 10;
  localparam int CH = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [4:0]    cfg_addr = '0;
  logic [31:0]   cfg_wdata = '0;
  logic          arm = 1'b0;
  logic          smp_valid = 1'b0;
  logic          smp_ready;
  logic [CH-1:0] smp_data = '0;
  logic          trig_pulse, triggered, armed;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  la_trigger #(.CH(CH), .CNT_W(3), .PW_W(3)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .arm(arm), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .smp_data(smp_data), .trig_pulse(trig_pulse),
    .triggered(triggered), .armed(armed)
  );

  task automatic chk(input int act_v, input int exp_v, input string tag);
    n_chk++;
    if (act_v != exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act_v, exp_v);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_arm();
    arm = 1'b1;
    @(posedge clk); @(negedge clk);
    arm = 1'b0;
  endtask

  task automatic step(input logic [CH-1:0] s, input int exp_v, input string tag);
    smp_valid = 1'b1; smp_data = s;
    @(posedge clk); @(negedge clk);
    smp_valid = 1'b0;
    chk(int'(trig_pulse), exp_v, tag);
  endtask

  function automatic logic [4:0] ua(input int u, input int r);
    return {1'b0, 1'(u), 3'(r)};
  endfunction

  task automatic clear_cfg(input int mode);
    for (int u = 0; u < 2; u++) begin
      for (int r = 0; r < 4; r++) wr(ua(u, r), 32'h0);
      wr(ua(u, 4), 32'd1);
    end
    wr(5'h10, 32'(mode));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R10 actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(int'(trig_pulse), 0, "R1 pulse");
    chk(int'(triggered), 0, "R1 triggered");
    chk(int'(armed), 0, "R1 armed");
    chk(int'(smp_ready), 1, "R1 ready");

    // R11 / R10: disarmed and invalid samples ignored, latch behaviour
    clear_cfg(1);
    wr(ua(0, 1), 32'h0001_0001);
    step(4'h1, 0, "R11 disarmed");
    do_arm();
    chk(int'(armed), 1, "R10 armed");
    smp_valid = 1'b0; smp_data = 4'h1;
    @(posedge clk); @(negedge clk);
    chk(int'(trig_pulse), 0, "R11 valid low");
    arm = 1'b1; smp_valid = 1'b1; smp_data = 4'h1;
    @(posedge clk); @(negedge clk);
    arm = 1'b0; smp_valid = 1'b0;
    chk(int'(trig_pulse), 0, "R11 arm cycle");
    step(4'h1, 1, "R10 fire");
    chk(int'(triggered), 1, "R10 triggered");
    chk(int'(armed), 0, "R10 disarmed");
    step(4'h1, 0, "R10 no second pulse");
    chk(int'(triggered), 1, "R10 latched");
    do_arm();
    chk(int'(triggered), 0, "R10 rearm clears");

    // R2 edge kinds on every channel (0 rise, 1 fall, 2 any)
    for (int c = 0; c < CH; c++) begin
      for (int k = 0; k < 3; k++) begin
        logic [CH-1:0] b;
        logic [31:0] d;
        b = CH'(1) << c;
        d = 32'h0;
        if (k != 1) d[c] = 1'b1;
        if (k != 0) d[16 + c] = 1'b1;
        clear_cfg(1);
        wr(ua(0, 0), d);
        do_arm();
        step(4'h0, 0, "R2 first sample");
        step(~b, 0, "R2 other channels rise");
        step(4'hF, (k != 1) ? 1 : 0, "R2 rising edge");
        if (k == 1) begin
          step(b, 0, "R2 other channels fall");
          step(4'h0, 1, "R2 falling edge");
        end
      end
    end
    // R2 first accepted sample after arm makes no edge
    clear_cfg(1);
    wr(ua(0, 0), 32'h0000_0001);
    step(4'h0, 0, "R2 disarmed sample");
    do_arm();
    step(4'h1, 0, "R2 no edge on first sample");
    step(4'h0, 0, "R2 low");
    step(4'h1, 1, "R2 edge after history");

    // R3 full level sweep
    clear_cfg(1);
    for (int v = 0; v < 16; v++) begin
      wr(ua(0, 1), (32'(v) << 16) | 32'hF);
      for (int s = 0; s < 16; s++) begin
        do_arm();
        step(4'(s), (s == v) ? 1 : 0, "R3 level all channels");
      end
    end
    wr(ua(0, 1), 32'h0001_0005);
    for (int s = 0; s < 16; s++) begin
      do_arm();
      step(4'(s), ((s & 5) == 1) ? 1 : 0, "R3 partial mask");
    end

    // R5 edge OR and edge AND level
    clear_cfg(1);
    wr(ua(0, 0), 32'h0000_0005);
    do_arm(); step(4'h0, 0, "R5 base"); step(4'h4, 1, "R5 edge ch2");
    do_arm(); step(4'h0, 0, "R5 base"); step(4'h1, 1, "R5 edge ch0");
    wr(ua(0, 0), 32'h0000_0001);
    wr(ua(0, 1), 32'h0008_0008);
    do_arm();
    step(4'h0, 0, "R5 base");
    step(4'h1, 0, "R5 edge without level");
    step(4'h8, 0, "R5 level without edge");
    step(4'h9, 1, "R5 edge with level");
    clear_cfg(1);
    do_arm();
    step(4'h0, 0, "R5 no terms"); step(4'hF, 0, "R5 no terms");

    // R4 qualified edges
    clear_cfg(1);
    wr(ua(0, 2), 32'h0000_1103);
    do_arm();
    step(4'h0, 0, "R4 base");
    step(4'h1, 0, "R4 rise, qualifier low");
    step(4'h2, 0, "R4 fall, qualifier high");
    step(4'h3, 1, "R4 rise, qualifier high");
    wr(ua(0, 2), 32'h0000_0105);
    do_arm();
    step(4'h3, 0, "R4 base");
    step(4'h2, 0, "R4 fall, qualifier high");
    step(4'h1, 0, "R4 base");
    step(4'h0, 1, "R4 fall, qualifier low");

    // R6 pulse window and saturation
    clear_cfg(1);
    wr(ua(0, 1), 32'h0001_0001);
    wr(ua(0, 2), 32'h0001_0000);
    wr(ua(0, 3), 32'h0003_0002);
    for (int len = 1; len <= 5; len++) begin
      do_arm();
      step(4'h0, 0, "R6 base");
      for (int i = 0; i < len; i++) step(4'h1, 0, "R6 level held");
      step(4'h0, (len >= 2 && len <= 3) ? 1 : 0, "R6 pulse end");
    end
    do_arm();
    for (int i = 0; i < 10; i++) step(4'h1, 0, "R6 long level");
    step(4'h0, 0, "R6 saturated above window");
    wr(ua(0, 3), 32'h0007_0006);
    do_arm();
    for (int i = 0; i < 10; i++) step(4'h1, 0, "R6 long level");
    step(4'h0, 1, "R6 saturated in window");

    // R7 occurrence count
    clear_cfg(1);
    wr(ua(0, 0), 32'h0000_0001);
    for (int n = 0; n <= 4; n++) begin
      int eff;
      eff = (n == 0) ? 1 : n;
      wr(ua(0, 4), 32'(n));
      do_arm();
      for (int k = 1; k <= eff; k++) begin
        step(4'h0, 0, "R7 low");
        step(4'h1, (k == eff) ? 1 : 0, "R7 count");
      end
    end
    wr(ua(0, 4), 32'd2);
    do_arm(); step(4'h0, 0, "R7 low"); step(4'h1, 0, "R7 first match");
    do_arm(); step(4'h0, 0, "R7 low"); step(4'h1, 0, "R7 count cleared by arm");
    step(4'h0, 0, "R7 low"); step(4'h1, 1, "R7 second match");

    // R8 AND / OR / reserved
    clear_cfg(0);
    wr(ua(0, 1), 32'h0001_0001);
    wr(ua(1, 1), 32'h0002_0002);
    do_arm();
    step(4'h1, 0, "R8 and, A only");
    step(4'h0, 0, "R8 and, idle");
    step(4'h2, 1, "R8 and, B later");
    do_arm(); step(4'h3, 1, "R8 and, both at once");
    wr(5'h10, 32'd1);
    do_arm(); step(4'h2, 1, "R8 or, B alone");
    do_arm(); step(4'h0, 0, "R8 or, none"); step(4'h1, 1, "R8 or, A alone");
    wr(5'h10, 32'd3);
    do_arm(); step(4'h2, 0, "R8 mode3, B only"); step(4'h1, 1, "R8 mode3, A later");

    // R9 A then B
    wr(5'h10, 32'd2);
    do_arm();
    step(4'h2, 0, "R9 B before A");
    step(4'h1, 0, "R9 A fires");
    step(4'h2, 1, "R9 B after A");
    do_arm();
    step(4'h3, 0, "R9 same sample");
    step(4'h3, 1, "R9 next sample");
    do_arm(); step(4'h1, 0, "R9 A fires");
    do_arm(); step(4'h2, 0, "R10 sequence cleared by arm");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule